// File: doc/BRIEF.md
# Associative Translation Buffer

This block is a small, fully associative translation cache whose contents are managed entirely by software. Every slot holds a virtual page number, a page mask of the same width, an address-space tag, a global flag, a pair of valid bits and a physical frame number. Any virtual page bit whose mask bit is 1 is left out of the comparison, so one slot can cover a larger page.

Two independent combinational search paths are provided. The lookup path returns a hit flag, the physical frame and the slot that hit. The probe path returns only the slot number, or all ones when nothing matches. Software fills a slot by writing its index directly. It chooses a victim through a round-robin pointer that steps forward on request. A flush command empties the whole table and sends the pointer back to slot zero. Walking page tables and raising faults are left to the surrounding logic.

Top module: `assoc_xlate_buf`

## Requirements
- R1: A slot's virtual page compares equal to the request when the two agree in every bit where that slot's mask bit is 0. Bits whose mask bit is 1 are ignored.
- R2: A page match counts as a hit only when the slot's global flag is 1 or the slot's address-space tag equals the request's tag.
- R3: The lookup outputs are combinational. On a hit they give `lkHit`=1, the slot's frame and the slot index. On a miss they give `lkHit`=0, frame 0 and index 0.
- R4: The probe output `prIdx` is combinational. It gives the index of the matching slot, or all ones (-1 in two's complement, 4'hF with default parameters) on a miss.
- R5: A slot is live when at least one of its two valid bits is 1. A slot with both valid bits at 0 never matches.
- R6: A write whose `wrIdx` is NUM_ENTRIES or larger changes no slot. `wrErr` is 1 for exactly the one cycle after such a request and 0 otherwise.
- R7: An in-range write replaces every field of the target slot. The new contents are visible from the next rising clock edge.
- R8: A flush makes every slot dead and sets the replacement pointer to 0 at the next edge. A write or pointer advance in the same cycle loses to the flush.
- R9: `rpIdx` shows the current victim index. A cycle with `rpAdvance`=1 increments it at the next edge, and with `rpAdvance`=0 it holds.
- R10: The pointer wraps from NUM_ENTRIES-1 back to 0.
- R11: When several slots hit, the lowest-numbered one is reported on both the lookup and the probe path.
- R12: Synchronous reset (`rst_n`=0) has the same effect as a flush: every slot is dead, the pointer is 0 and `wrErr` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| lkVpn | input | VPN_W | Lookup virtual page |
| lkAsid | input | ASID_W | Lookup address-space tag |
| lkHit | output | 1 | Lookup hit |
| lkPfn | output | PFN_W | Frame of the hitting slot, 0 on a miss |
| lkIdx | output | IDX_W | Index of the hitting slot, 0 on a miss |
| prVpn | input | VPN_W | Probe virtual page |
| prAsid | input | ASID_W | Probe address-space tag |
| prIdx | output | IDX_W | Probe result, all ones on a miss |
| wrEn | input | 1 | Indexed write request |
| wrIdx | input | IDX_W | Target slot of the write |
| wrVpn | input | VPN_W | New virtual page |
| wrMask | input | VPN_W | New page mask, 1 = ignore the bit |
| wrAsid | input | ASID_W | New address-space tag |
| wrGlobal | input | 1 | New global flag |
| wrValid | input | 2 | New valid bit pair |
| wrPfn | input | PFN_W | New physical frame |
| wrErr | output | 1 | One-cycle pulse after an out-of-range write |
| flush | input | 1 | Empty the table and reset the pointer |
| rpAdvance | input | 1 | Step the replacement pointer |
| rpIdx | output | IDX_W | Current replacement victim |

## Verification
The bench builds a table in which slots overlap on purpose: two slots cover the same page, one of them wider through its mask, and a global slot shares a page with a tagged one. A design that picked the highest slot, or chose a slot at random, would then report the wrong index or frame. It also uses a slot with only its upper valid bit set, a fully written slot with both valid bits clear, and an all-zero slot left over from reset. A design that tested only one valid bit, or ignored the valid bits, would miss the first or falsely hit the others. Writes to index NUM_ENTRIES and above must leave the original translation in place and pulse the error for one cycle. A flush arrives together with a write and after the pointer has moved, and the pointer is stepped across its wrap. A design with an off-by-one range check, a write that wins over the flush, or a pointer that runs past the last slot would fail these checks.

// File: rtl/xbuf_pkg.sv
package xbuf_pkg;

  // Strobes the control block hands to the datapath each cycle.
  typedef struct packed {
    logic doWrite;    // commit the write fields into the selected slot
    logic doFlush;    // kill every slot
    logic doAdvance;  // pointer step accepted
  } xbufStrobe_t;

endpackage

// File: rtl/xbuf_pick.sv
// Lowest-index-first priority pick over a match vector.
module xbuf_pick #(
  parameter int N     = 8,
  parameter int SEL_W = 3
) (
  input  logic [N-1:0]     matchVec,
  output logic             anyHit,
  output logic [SEL_W-1:0] firstIdx
);

  always_comb begin
    firstIdx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (matchVec[i]) firstIdx = SEL_W'(i);
    end
    anyHit = |matchVec;
  end

endmodule

// File: rtl/xbuf_ctrl.sv
// Write range check, flush priority and round-robin victim pointer.
module xbuf_ctrl
  import xbuf_pkg::*;
#(
  parameter int NUM_ENTRIES = 8,
  parameter int IDX_W       = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wrEn,
  input  logic [IDX_W-1:0] wrIdx,
  input  logic             flush,
  input  logic             rpAdvance,
  output xbufStrobe_t      strobe,
  output logic             wrErr,
  output logic [IDX_W-1:0] rpIdx
);

  localparam logic [IDX_W-1:0] SLOT_LIMIT = IDX_W'(NUM_ENTRIES);
  localparam logic [IDX_W-1:0] LAST_SLOT  = IDX_W'(NUM_ENTRIES - 1);

  logic inRange;
  logic [IDX_W-1:0] ptrQ;

  assign inRange = (wrIdx < SLOT_LIMIT);

  always_comb begin
    strobe.doFlush   = flush;
    strobe.doWrite   = wrEn && inRange && !flush;
    strobe.doAdvance = rpAdvance && !flush;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || strobe.doFlush) begin
      ptrQ <= '0;
    end else if (strobe.doAdvance) begin
      ptrQ <= (ptrQ == LAST_SLOT) ? '0 : ptrQ + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) wrErr <= 1'b0;
    else        wrErr <= wrEn && !inRange;
  end

  assign rpIdx = ptrQ;

  // R6: the error pulse only follows an out-of-range request
  a_r6_err_source: assert property (@(posedge clk) disable iff (!rst_n)
    wrErr |-> ($past(wrEn) && ($past(wrIdx) >= SLOT_LIMIT)));

  // R8: flush sends the pointer home
  a_r8_flush_ptr: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (rpIdx == '0));

  // R10: stepping from the last slot wraps to zero
  a_r10_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (rpAdvance && !flush && rpIdx == LAST_SLOT) |=> (rpIdx == '0));

  // R9: pointer holds without a request
  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!rpAdvance && !flush) |=> $stable(rpIdx));

  // R9: pointer never leaves the table
  a_r9_in_table: assert property (@(posedge clk) disable iff (!rst_n)
    rpIdx < SLOT_LIMIT);

endmodule

// File: rtl/xbuf_data.sv
// Slot storage and the two parallel match paths.
module xbuf_data
  import xbuf_pkg::*;
#(
  parameter int NUM_ENTRIES = 8,
  parameter int VPN_W       = 20,
  parameter int PFN_W       = 20,
  parameter int ASID_W      = 8,
  parameter int IDX_W       = 4,
  parameter int SEL_W       = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  xbufStrobe_t       strobe,
  input  logic [SEL_W-1:0]  wrSel,
  input  logic [VPN_W-1:0]  wrVpn,
  input  logic [VPN_W-1:0]  wrMask,
  input  logic [ASID_W-1:0] wrAsid,
  input  logic              wrGlobal,
  input  logic [1:0]        wrValid,
  input  logic [PFN_W-1:0]  wrPfn,
  input  logic [VPN_W-1:0]  lkVpn,
  input  logic [ASID_W-1:0] lkAsid,
  output logic              lkHit,
  output logic [PFN_W-1:0]  lkPfn,
  output logic [IDX_W-1:0]  lkIdx,
  input  logic [VPN_W-1:0]  prVpn,
  input  logic [ASID_W-1:0] prAsid,
  output logic [IDX_W-1:0]  prIdx
);

  logic [VPN_W-1:0]  eVpn   [NUM_ENTRIES];
  logic [VPN_W-1:0]  eMask  [NUM_ENTRIES];
  logic [ASID_W-1:0] eAsid  [NUM_ENTRIES];
  logic              eGlob  [NUM_ENTRIES];
  logic [1:0]        eValid [NUM_ENTRIES];
  logic [PFN_W-1:0]  ePfn   [NUM_ENTRIES];

  logic [NUM_ENTRIES-1:0] liveVec;
  logic [NUM_ENTRIES-1:0] lkMatchVec;
  logic [NUM_ENTRIES-1:0] prMatchVec;
  logic [SEL_W-1:0] lkSel;
  logic [SEL_W-1:0] prSel;
  logic lkAny;
  logic prAny;

  always_ff @(posedge clk) begin
    if (!rst_n || strobe.doFlush) begin
      for (int i = 0; i < NUM_ENTRIES; i++) begin
        eVpn[i]   <= '0;
        eMask[i]  <= '0;
        eAsid[i]  <= '0;
        eGlob[i]  <= 1'b0;
        eValid[i] <= 2'b00;
        ePfn[i]   <= '0;
      end
    end else if (strobe.doWrite) begin
      eVpn[wrSel]   <= wrVpn;
      eMask[wrSel]  <= wrMask;
      eAsid[wrSel]  <= wrAsid;
      eGlob[wrSel]  <= wrGlobal;
      eValid[wrSel] <= wrValid;
      ePfn[wrSel]   <= wrPfn;
    end
  end

  for (genvar g = 0; g < NUM_ENTRIES; g++) begin : gSlot
    assign liveVec[g] = |eValid[g];
    assign lkMatchVec[g] = liveVec[g]
        && (((lkVpn ^ eVpn[g]) & ~eMask[g]) == '0)
        && (eGlob[g] || (eAsid[g] == lkAsid));
    assign prMatchVec[g] = liveVec[g]
        && (((prVpn ^ eVpn[g]) & ~eMask[g]) == '0)
        && (eGlob[g] || (eAsid[g] == prAsid));
  end

  xbuf_pick #(.N(NUM_ENTRIES), .SEL_W(SEL_W)) lkPick_i (
    .matchVec(lkMatchVec), .anyHit(lkAny), .firstIdx(lkSel));

  xbuf_pick #(.N(NUM_ENTRIES), .SEL_W(SEL_W)) prPick_i (
    .matchVec(prMatchVec), .anyHit(prAny), .firstIdx(prSel));

  assign lkHit = lkAny;
  assign lkPfn = lkAny ? ePfn[lkSel] : '0;
  assign lkIdx = lkAny ? IDX_W'(lkSel) : '0;
  assign prIdx = prAny ? IDX_W'(prSel) : '1;

  // R8: after a flush no slot is live
  a_r8_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.doFlush |=> (liveVec == '0));

  // R5: a reported hit always names a live slot
  a_r5_hit_live: assert property (@(posedge clk) disable iff (!rst_n)
    lkHit |-> liveVec[lkSel]);

  // R11: no lower slot also matched
  a_r11_lowest_wins: assert property (@(posedge clk) disable iff (!rst_n)
    lkHit |-> ((lkMatchVec & ((NUM_ENTRIES'(1) << lkSel) - NUM_ENTRIES'(1))) == '0));

  // R4: probe and lookup agree when asked the same question
  a_r4_paths_agree: assert property (@(posedge clk) disable iff (!rst_n)
    (prVpn == lkVpn && prAsid == lkAsid) |-> (lkHit ? (prIdx == lkIdx) : (prIdx == '1)));

  // R7: a committed write is live exactly as written
  a_r7_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.doWrite && !strobe.doFlush) |=> (eValid[$past(wrSel)] == $past(wrValid)));

endmodule

// File: rtl/assoc_xlate_buf.sv
// Thin top: control and datapath wired through the strobe struct.
module assoc_xlate_buf
  import xbuf_pkg::*;
#(
  parameter int NUM_ENTRIES = 8,
  parameter int VPN_W       = 20,
  parameter int PFN_W       = 20,
  parameter int ASID_W      = 8,
  parameter int IDX_W       = $clog2(NUM_ENTRIES) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [VPN_W-1:0]  lkVpn,
  input  logic [ASID_W-1:0] lkAsid,
  output logic              lkHit,
  output logic [PFN_W-1:0]  lkPfn,
  output logic [IDX_W-1:0]  lkIdx,
  input  logic [VPN_W-1:0]  prVpn,
  input  logic [ASID_W-1:0] prAsid,
  output logic [IDX_W-1:0]  prIdx,
  input  logic              wrEn,
  input  logic [IDX_W-1:0]  wrIdx,
  input  logic [VPN_W-1:0]  wrVpn,
  input  logic [VPN_W-1:0]  wrMask,
  input  logic [ASID_W-1:0] wrAsid,
  input  logic              wrGlobal,
  input  logic [1:0]        wrValid,
  input  logic [PFN_W-1:0]  wrPfn,
  output logic              wrErr,
  input  logic              flush,
  input  logic              rpAdvance,
  output logic [IDX_W-1:0]  rpIdx
);

  localparam int SEL_W = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1;

  xbufStrobe_t strobe;

  xbuf_ctrl #(.NUM_ENTRIES(NUM_ENTRIES), .IDX_W(IDX_W)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .wrEn(wrEn), .wrIdx(wrIdx), .flush(flush),
    .rpAdvance(rpAdvance), .strobe(strobe), .wrErr(wrErr), .rpIdx(rpIdx));

  xbuf_data #(
    .NUM_ENTRIES(NUM_ENTRIES), .VPN_W(VPN_W), .PFN_W(PFN_W),
    .ASID_W(ASID_W), .IDX_W(IDX_W), .SEL_W(SEL_W)
  ) data_i (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .wrSel(wrIdx[SEL_W-1:0]),
    .wrVpn(wrVpn), .wrMask(wrMask), .wrAsid(wrAsid), .wrGlobal(wrGlobal),
    .wrValid(wrValid), .wrPfn(wrPfn),
    .lkVpn(lkVpn), .lkAsid(lkAsid), .lkHit(lkHit), .lkPfn(lkPfn), .lkIdx(lkIdx),
    .prVpn(prVpn), .prAsid(prAsid), .prIdx(prIdx));

endmodule

// File: tb/assoc_xlate_buf_tb_top.sv
module assoc_xlate_buf_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int N = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [19:0] lkVpn = '0, prVpn = '0, wrVpn = '0, wrMask = '0, wrPfn = '0;
  logic [7:0]  lkAsid = '0, prAsid = '0, wrAsid = '0;
  logic        wrEn = 1'b0, wrGlobal = 1'b0, flush = 1'b0, rpAdvance = 1'b0;
  logic [1:0]  wrValid = '0;
  logic [3:0]  wrIdx = '0;
  logic        lkHit, wrErr;
  logic [19:0] lkPfn;
  logic [3:0]  lkIdx, prIdx, rpIdx;

  int testsRun = 0;
  int testsFailed = 0;
  bit finished = 1'b0;

  // behavioural reference table
  logic [19:0] refPfn [N];

  always #(CLK_PERIOD / 2) clk = ~clk;

  assoc_xlate_buf dut_i (
    .clk(clk), .rst_n(rst_n), .lkVpn(lkVpn), .lkAsid(lkAsid), .lkHit(lkHit),
    .lkPfn(lkPfn), .lkIdx(lkIdx), .prVpn(prVpn), .prAsid(prAsid), .prIdx(prIdx),
    .wrEn(wrEn), .wrIdx(wrIdx), .wrVpn(wrVpn), .wrMask(wrMask), .wrAsid(wrAsid),
    .wrGlobal(wrGlobal), .wrValid(wrValid), .wrPfn(wrPfn), .wrErr(wrErr),
    .flush(flush), .rpAdvance(rpAdvance), .rpIdx(rpIdx));

  typedef struct packed {
    logic [3:0]  idx;
    logic [19:0] vpn;
    logic [19:0] mask;
    logic [7:0]  asid;
    logic        glob;
    logic [1:0]  valid;
    logic [19:0] pfn;
  } wrVec_t;

  localparam wrVec_t WR_VECS [7] = '{
    '{4'd0, 20'h12340, 20'h00000, 8'd5, 1'b0, 2'b01, 20'hA0000},
    '{4'd1, 20'h12340, 20'h00000, 8'd7, 1'b0, 2'b10, 20'hA1111},
    '{4'd2, 20'h55500, 20'h000FF, 8'd3, 1'b0, 2'b11, 20'hB2222},
    '{4'd3, 20'h77770, 20'h00000, 8'd9, 1'b1, 2'b01, 20'hC3333},
    '{4'd4, 20'h99990, 20'h00000, 8'd1, 1'b0, 2'b00, 20'hD4444},
    '{4'd5, 20'h55500, 20'h0000F, 8'd3, 1'b0, 2'b01, 20'hE5555},
    '{4'd6, 20'h77770, 20'h00000, 8'd2, 1'b0, 2'b01, 20'hF6666}
  };

  typedef struct packed {
    logic [19:0] vpn;
    logic [7:0]  asid;
    logic        hit;
    logic [3:0]  idx;
  } lkVec_t;

  localparam lkVec_t LK_VECS [12] = '{
    '{20'h12340, 8'd5,   1'b1, 4'd0},  // R1 exact page
    '{20'h12340, 8'd7,   1'b1, 4'd1},  // R5 upper valid bit only
    '{20'h12340, 8'd6,   1'b0, 4'd0},  // R2 tag mismatch
    '{20'h12341, 8'd5,   1'b0, 4'd0},  // R1 unmasked bit differs
    '{20'h555AB, 8'd3,   1'b1, 4'd2},  // R1 masked bits ignored
    '{20'h556AB, 8'd3,   1'b0, 4'd0},  // R1 bit 8 outside both masks
    '{20'h5550C, 8'd3,   1'b1, 4'd2},  // R11 slots 2 and 5 both hit
    '{20'h5550C, 8'd4,   1'b0, 4'd0},  // R2 tag mismatch
    '{20'h77770, 8'd200, 1'b1, 4'd3},  // R2 global slot, any tag
    '{20'h77770, 8'd2,   1'b1, 4'd3},  // R11 slots 3 and 6 both hit
    '{20'h99990, 8'd1,   1'b0, 4'd0},  // R5 both valid bits clear
    '{20'h00000, 8'd0,   1'b0, 4'd0}   // R5 zero slot 7 from reset
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic refClear();
    for (int i = 0; i < N; i++) refPfn[i] = '0;
  endtask

  task automatic writeSlot(input wrVec_t v);
    @(negedge clk);
    wrEn = 1'b1; wrIdx = v.idx; wrVpn = v.vpn; wrMask = v.mask;
    wrAsid = v.asid; wrGlobal = v.glob; wrValid = v.valid; wrPfn = v.pfn;
    @(negedge clk);
    wrEn = 1'b0;
    if (v.idx < 4'(N)) refPfn[v.idx[2:0]] = v.pfn;
  endtask

  task automatic lookCheck(input string req, input logic [19:0] vpn, input logic [7:0] asid,
                           input logic expHit, input logic [3:0] expIdx);
    lkVpn = vpn; lkAsid = asid; prVpn = vpn; prAsid = asid;
    #1;
    chk({req, " hit"}, 32'(lkHit), 32'(expHit));
    chk({req, " idx"}, 32'(lkIdx), expHit ? 32'(expIdx) : 32'd0);
    chk({req, " pfn"}, 32'(lkPfn), expHit ? 32'(refPfn[expIdx[2:0]]) : 32'd0);
    chk({req, " probe"}, 32'(prIdx), expHit ? 32'(expIdx) : 32'hF);
  endtask

  task automatic advanceOnce();
    @(negedge clk); rpAdvance = 1'b1;
    @(negedge clk); rpAdvance = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      testsFailed++;
      testsRun++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  initial begin
    refClear();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R12 reset state
    chk("R12 pointer", 32'(rpIdx), 32'd0);
    chk("R12 wrErr", 32'(wrErr), 32'd0);
    lookCheck("R12 empty", 20'h00000, 8'd0, 1'b0, 4'd0);

    // R7 fill the table, then walk the lookup vectors
    for (int i = 0; i < 7; i++) writeSlot(WR_VECS[i]);
    @(negedge clk);
    for (int i = 0; i < 12; i++) begin
      lookCheck($sformatf("R3 vec%0d", i), LK_VECS[i].vpn, LK_VECS[i].asid,
                LK_VECS[i].hit, LK_VECS[i].idx);
    end

    // R6 out-of-range writes, boundary index 8 and index 9
    writeSlot('{4'd8, 20'h12340, 20'h0, 8'd5, 1'b0, 2'b11, 20'h11111});
    chk("R6 err pulse idx8", 32'(wrErr), 32'd1);
    @(negedge clk);
    chk("R6 err one cycle", 32'(wrErr), 32'd0);
    writeSlot('{4'd9, 20'h12340, 20'h0, 8'd5, 1'b0, 2'b11, 20'h22222});
    chk("R6 err pulse idx9", 32'(wrErr), 32'd1);
    lookCheck("R6 slot0 kept", 20'h12340, 8'd5, 1'b1, 4'd0);

    // R7 overwrite slot 0 completely
    writeSlot('{4'd0, 20'h33330, 20'h0, 8'd5, 1'b0, 2'b10, 20'h12121});
    chk("R7 no err", 32'(wrErr), 32'd0);
    lookCheck("R7 old page gone", 20'h12340, 8'd5, 1'b0, 4'd0);
    lookCheck("R7 new page", 20'h33330, 8'd5, 1'b1, 4'd0);

    // R9 / R10 replacement pointer
    advanceOnce();
    chk("R9 step to 1", 32'(rpIdx), 32'd1);
    @(negedge clk);
    chk("R9 hold", 32'(rpIdx), 32'd1);
    for (int i = 0; i < 6; i++) advanceOnce();
    chk("R9 at last", 32'(rpIdx), 32'd7);
    advanceOnce();
    chk("R10 wrap", 32'(rpIdx), 32'd0);
    for (int i = 0; i < 3; i++) advanceOnce();
    chk("R9 at 3", 32'(rpIdx), 32'd3);

    // R8 flush together with a write and an advance
    @(negedge clk);
    flush = 1'b1; rpAdvance = 1'b1; wrEn = 1'b1; wrIdx = 4'd2;
    wrVpn = 20'hABCD0; wrMask = '0; wrAsid = 8'd1; wrGlobal = 1'b0;
    wrValid = 2'b11; wrPfn = 20'h55555;
    @(negedge clk);
    flush = 1'b0; rpAdvance = 1'b0; wrEn = 1'b0;
    refClear();
    chk("R8 pointer zero", 32'(rpIdx), 32'd0);
    lookCheck("R8 write lost", 20'hABCD0, 8'd1, 1'b0, 4'd0);
    lookCheck("R8 slot2 gone", 20'h555AB, 8'd3, 1'b0, 4'd0);
    lookCheck("R8 global gone", 20'h77770, 8'd9, 1'b0, 4'd0);

    // R12 reset in mid-run clears like a flush
    writeSlot(WR_VECS[3]);
    lookCheck("R12 pre reset", 20'h77770, 8'd9, 1'b1, 4'd3);
    advanceOnce();
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    refClear();
    @(negedge clk);
    lookCheck("R12 post reset", 20'h77770, 8'd9, 1'b0, 4'd0);
    chk("R12 pointer after reset", 32'(rpIdx), 32'd0);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule